// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block stands in for the command side of a parallel NOR flash. A host drives a simple single-cycle bus: a write carries an address, a data word and a byte count, and a read returns a word one cycle later. Writes are decoded as command bytes taken from the low byte of the data. The decoded command moves an internal mode register. That mode then decides what later reads return: the stored array word, the status byte, an identifier word, or a byte fetched from an external query table through a dedicated table port.

The array is held in an internal synchronous store. Each word also carries a blank flag, so a freshly reset or erased word reads as all ones. Programming merges the new word into the old one with a bitwise AND, so a bit can only be cleared. Erase restores a whole aligned block to all ones. Bus byte addresses are first normalised: they are shifted right by one bit on a 16-bit bus, by two bits on a 32-bit bus, and not at all on an 8-bit bus. Command decoding uses the normalised address. The array uses its low bits, so the array repeats across the address space.

Top module: `nfc_flash_cmd`

## Requirements
- R1: After reset the block is in array-read mode, the status byte is 0x80 (bit 7 ready, bit 5 erase error, bit 4 program error, all other bits zero), and every array word reads as all ones.
- R2: Outside program setup, a write of 0xFF or 0xF0 returns the block to array-read mode from any mode and leaves the status unchanged.
- R3: In array-read or identifier mode, command 0x98 enters query mode only when the normalised address is 0x55; at any other address it has no effect and raises no unknown flag. In query mode a read drives the normalised address on `tbl_addr`, asserts `tbl_rd`, and returns `tbl_data` zero-extended one cycle later.
- R4: The normalised address is the bus byte address shifted right by 0, 1 or 2 bits for a bus of 1, 2 or 4 bytes; the array index is its low log2(ARR_WORDS) bits.
- R5: A write whose `bus_wbytes` differs from BUS_BYTES has no effect on mode, status or array.
- R6: In array-read or identifier mode, 0x40 or 0x10 enters program setup. The next valid write is data: the addressed word becomes old AND new, and the mode becomes status. 0xFF written there is data, not a reset.
- R7: In erase setup (entered by 0x20), 0xD0 sets every word of the aligned block of BLK_WORDS words that holds the addressed word to all ones and clears both error bits. Any other value except 0xFF/0xF0 sets both error bits and leaves the array unchanged. In both cases the mode becomes status.
- R8: In protection setup (entered by 0x60), the values 0x01, 0xD0 and 0x2F are accepted without further effect. Any other value except 0xFF/0xF0 sets both error bits. In both cases the mode becomes status.
- R9: Command 0x50 in array-read or identifier mode clears both error bits and leaves the mode unchanged.
- R10: Reads in status or erase-setup mode return the status byte, zero-extended.
- R11: In identifier mode a read decodes normalised address bits 8:0: 0 returns MAKER_CODE, 1 returns 0x00AD, 2 returns 0x0000, 5 returns 0x8000; any other value returns zero.
- R12: Any other command byte, and any non-reset command in query or status mode, leaves mode and status unchanged and raises `cmd_unknown` for exactly the one cycle after the write.
- R13: Reads in program-setup or protection-setup mode return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8*BUS_BYTES | Write data; the low byte is the command |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wbytes | input | 3 | Byte count of the write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8*BUS_BYTES | Read data, valid the cycle after `bus_rd`, held until the next read |
| tbl_rd | output | 1 | Query table fetch, same cycle as the read |
| tbl_addr | output | ADDR_W-shift | Normalised address presented to the query table |
| tbl_data | input | 8 | Query table byte, sampled in the `tbl_rd` cycle |
| cmd_unknown | output | 1 | One-cycle flag for an unrecognised command |

## Verification
The properties assume that the host never raises `bus_rd` and `bus_wr` in the same cycle. They also assume that every strobe lasts one cycle, and that `tbl_data` is a settled function of `tbl_addr` while `tbl_rd` is high. The bench drives each access on the falling edge, holds it for one full cycle and idles in between, so reads never overlap writes. The table is modelled as a fixed arithmetic function of the address. Mode-based checks are only made on valid-width writes, and the bench issues mismatched widths only where R5 is under test.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [2:0] {
    ST_ARRAY,
    ST_IDENT,
    ST_QUERY,
    ST_PROTECT,
    ST_STATUS,
    ST_ERASE,
    ST_PROGRAM
  } nfc_state_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RESET      = 8'hF0;
  localparam logic [7:0] CMD_QUERY      = 8'h98;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_PROTECT    = 8'h60;
  localparam logic [7:0] CMD_LOCK       = 8'h01;
  localparam logic [7:0] CMD_UNLOCK     = 8'hD0;
  localparam logic [7:0] CMD_LOCKDOWN   = 8'h2F;

  localparam int QUERY_NORM_ADDR = 'h55;

  localparam int SR_READY    = 7;
  localparam int SR_ERASE_ER = 5;
  localparam int SR_PROG_ER  = 4;

  // right shift that turns a byte address into a word address
  function automatic int addr_shift(input int bus_bytes);
    if (bus_bytes == 4) return 2;
    if (bus_bytes == 2) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] status_byte(input logic ee, input logic pe);
    logic [7:0] b;
    b = 8'h00;
    b[SR_READY]    = 1'b1;
    b[SR_ERASE_ER] = ee;
    b[SR_PROG_ER]  = pe;
    return b;
  endfunction

  function automatic logic [15:0] ident_word(input logic [8:0] off,
                                             input logic [15:0] maker);
    case (off)
      9'd0:    return maker;
      9'd1:    return 16'h00AD;
      9'd2:    return 16'h0000;
      9'd5:    return 16'h8000;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic is_reset_cmd(input logic [7:0] c);
    return (c == CMD_READ_ARRAY) || (c == CMD_RESET);
  endfunction

endpackage

// File: rtl/nfc_cmd_fsm.sv
module nfc_cmd_fsm
  import nfc_pkg::*;
#(
  parameter int NORM_W = 9
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [7:0]        cmd,
  input  logic [NORM_W-1:0] norm,
  output nfc_state_e        state,
  output logic              err_e,
  output logic              err_p,
  output logic              do_prog,
  output logic              do_erase,
  output logic              unk_q
);

  nfc_state_e state_q, state_d;
  logic ee_q, ee_d, pe_q, pe_d, unk_d;

  always_comb begin
    state_d  = state_q;
    ee_d     = ee_q;
    pe_d     = pe_q;
    unk_d    = 1'b0;
    do_prog  = 1'b0;
    do_erase = 1'b0;
    if (wr_ok) begin
      if (state_q == ST_PROGRAM) begin
        do_prog = 1'b1;
        state_d = ST_STATUS;
      end else if (is_reset_cmd(cmd)) begin
        state_d = ST_ARRAY;
      end else begin
        case (state_q)
          ST_ARRAY, ST_IDENT: begin
            case (cmd)
              CMD_QUERY: begin
                if (norm == NORM_W'(QUERY_NORM_ADDR)) state_d = ST_QUERY;
              end
              CMD_IDENT:              state_d = ST_IDENT;
              CMD_ERASE:              state_d = ST_ERASE;
              CMD_PROG_A, CMD_PROG_B: state_d = ST_PROGRAM;
              CMD_PROTECT:            state_d = ST_PROTECT;
              CMD_CLR_STATUS: begin
                ee_d = 1'b0;
                pe_d = 1'b0;
              end
              default:                unk_d = 1'b1;
            endcase
          end
          ST_ERASE: begin
            if (cmd == CMD_CONFIRM) begin
              do_erase = 1'b1;
              ee_d = 1'b0;
              pe_d = 1'b0;
            end else begin
              ee_d = 1'b1;
              pe_d = 1'b1;
            end
            state_d = ST_STATUS;
          end
          ST_PROTECT: begin
            if (!(cmd == CMD_LOCK || cmd == CMD_UNLOCK || cmd == CMD_LOCKDOWN)) begin
              ee_d = 1'b1;
              pe_d = 1'b1;
            end
            state_d = ST_STATUS;
          end
          default: unk_d = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ARRAY;
      ee_q    <= 1'b0;
      pe_q    <= 1'b0;
      unk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ee_q    <= ee_d;
      pe_q    <= pe_d;
      unk_q   <= unk_d;
    end
  end

  assign state = state_q;
  assign err_e = ee_q;
  assign err_p = pe_q;

endmodule

// File: rtl/nfc_word_store.sv
module nfc_word_store #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  parameter int BLK_W  = 4,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int BLKN_W = IDX_W - BLK_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              pgm_en,
  input  logic [IDX_W-1:0]  pgm_idx,
  input  logic [DATA_W-1:0] pgm_data,
  input  logic              ers_en,
  input  logic [BLKN_W-1:0] ers_blk,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  blank;
  logic [DATA_W-1:0] old_word;

  // a blank word holds all ones regardless of the stored bits
  assign old_word = blank[pgm_idx] ? {DATA_W{1'b1}} : mem[pgm_idx];

  always_ff @(posedge clk) begin
    if (pgm_en) mem[pgm_idx] <= old_word & pgm_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_blank
    localparam logic [BLKN_W-1:0] MY_BLK = BLKN_W'(g >> BLK_W);
    always_ff @(posedge clk) begin
      if (!rst_n)                                       blank[g] <= 1'b1;
      else if (ers_en && ers_blk == MY_BLK)             blank[g] <= 1'b1;
      else if (pgm_en && pgm_idx == IDX_W'(g))          blank[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_word <= '0;
    else if (rd_en) rd_word <= blank[rd_idx] ? {DATA_W{1'b1}} : mem[rd_idx];
  end

endmodule

// File: rtl/nfc_read_path.sv
module nfc_read_path
  import nfc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NORM_W = 9,
  parameter logic [15:0] MAKER_CODE = 16'h0042
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  nfc_state_e        state,
  input  logic [NORM_W-1:0] norm,
  input  logic              err_e,
  input  logic              err_p,
  input  logic [7:0]        qry_data,
  output logic              sel_arr_q,
  output logic [DATA_W-1:0] side_q
);

  logic [DATA_W-1:0] side_d;

  always_comb begin
    case (state)
      ST_STATUS, ST_ERASE: side_d = DATA_W'(status_byte(err_e, err_p));
      ST_IDENT:            side_d = DATA_W'(ident_word(9'(norm), MAKER_CODE));
      ST_QUERY:            side_d = DATA_W'(qry_data);
      default:             side_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_arr_q <= 1'b1;
      side_q    <= '0;
    end else if (rd_en) begin
      sel_arr_q <= (state == ST_ARRAY);
      side_q    <= side_d;
    end
  end

endmodule

// File: rtl/nfc_flash_cmd.sv
module nfc_flash_cmd
  import nfc_pkg::*;
#(
  parameter int BUS_BYTES = 2,
  parameter int ADDR_W    = 10,
  parameter int ARR_WORDS = 64,
  parameter int BLK_WORDS = 16,
  parameter logic [15:0] MAKER_CODE = 16'h0042,
  localparam int DATA_W = 8 * BUS_BYTES,
  localparam int SHIFT  = addr_shift(BUS_BYTES),
  localparam int NORM_W = ADDR_W - SHIFT
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic [2:0]        bus_wbytes,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tbl_rd,
  output logic [NORM_W-1:0] tbl_addr,
  input  logic [7:0]        tbl_data,
  output logic              cmd_unknown
);

  localparam int IDX_W = $clog2(ARR_WORDS);
  localparam int BLK_W = $clog2(BLK_WORDS);

  // named internal events, shared with the bound checker
  logic              wr_ok;
  logic [7:0]        cmd_byte;
  logic [NORM_W-1:0] norm_addr;
  logic [IDX_W-1:0]  arr_idx;
  nfc_state_e        fsm_state;
  logic              err_e, err_p, do_prog, do_erase;
  logic              sel_arr_q;
  logic [DATA_W-1:0] side_q, arr_word;

  assign wr_ok     = bus_wr && (bus_wbytes == 3'(BUS_BYTES));
  assign cmd_byte  = bus_wdata[7:0];
  assign norm_addr = NORM_W'(bus_addr >> SHIFT);
  assign arr_idx   = norm_addr[IDX_W-1:0];

  nfc_cmd_fsm #(.NORM_W(NORM_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .cmd      (cmd_byte),
    .norm     (norm_addr),
    .state    (fsm_state),
    .err_e    (err_e),
    .err_p    (err_p),
    .do_prog  (do_prog),
    .do_erase (do_erase),
    .unk_q    (cmd_unknown)
  );

  nfc_word_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd),
    .rd_idx   (arr_idx),
    .pgm_en   (do_prog),
    .pgm_idx  (arr_idx),
    .pgm_data (bus_wdata),
    .ers_en   (do_erase),
    .ers_blk  (arr_idx[IDX_W-1:BLK_W]),
    .rd_word  (arr_word)
  );

  nfc_read_path #(.DATA_W(DATA_W), .NORM_W(NORM_W), .MAKER_CODE(MAKER_CODE)) u_rpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (bus_rd),
    .state     (fsm_state),
    .norm      (norm_addr),
    .err_e     (err_e),
    .err_p     (err_p),
    .qry_data  (tbl_data),
    .sel_arr_q (sel_arr_q),
    .side_q    (side_q)
  );

  assign tbl_rd    = bus_rd && (fsm_state == ST_QUERY);
  assign tbl_addr  = norm_addr;
  assign bus_rdata = sel_arr_q ? arr_word : side_q;

endmodule

// File: rtl/nfc_flash_cmd_chk.sv
module nfc_flash_cmd_chk
  import nfc_pkg::*;
#(
  parameter int NORM_W = 9,
  parameter int DATA_W = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              wr_ok,
  input logic [7:0]        cmd_byte,
  input logic [NORM_W-1:0] norm_addr,
  input nfc_state_e        fsm_state,
  input logic              err_e,
  input logic              err_p,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cmd_unknown
);

  a_r2_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && fsm_state != ST_PROGRAM && (cmd_byte == 8'hFF || cmd_byte == 8'hF0)
    |=> fsm_state == ST_ARRAY);

  a_r3_query_wrong_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && (fsm_state == ST_ARRAY || fsm_state == ST_IDENT) && cmd_byte == 8'h98
      && norm_addr != NORM_W'(QUERY_NORM_ADDR)
    |=> $stable(fsm_state) && !cmd_unknown);

  a_r5_width_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !wr_ok |=> $stable(fsm_state) && $stable(err_e) && $stable(err_p));

  a_r6_prog_to_status: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && fsm_state == ST_PROGRAM |=> fsm_state == ST_STATUS);

  a_r7_erase_bad_value: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && fsm_state == ST_ERASE && cmd_byte != 8'hD0
      && cmd_byte != 8'hFF && cmd_byte != 8'hF0
    |=> err_e && err_p && fsm_state == ST_STATUS);

  a_r10_ready_bit: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && fsm_state == ST_STATUS |=> bus_rdata[7]);

  a_r12_unknown_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unknown |-> $past(wr_ok) && $stable(fsm_state) && $stable(err_e) && $stable(err_p));

endmodule

bind nfc_flash_cmd nfc_flash_cmd_chk #(.NORM_W(NORM_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .wr_ok       (wr_ok),
  .cmd_byte    (cmd_byte),
  .norm_addr   (norm_addr),
  .fsm_state   (fsm_state),
  .err_e       (err_e),
  .err_p       (err_p),
  .bus_rdata   (bus_rdata),
  .cmd_unknown (cmd_unknown)
);

// File: tb/sim_nfc_flash_cmd.sv
module sim_nfc_flash_cmd;

  localparam int AW = 10;
  localparam int NW = 9;
  localparam int DW = 16;
  localparam logic [15:0] MAKER = 16'h0042;
  localparam logic [15:0] SR_OK  = 16'h0080;
  localparam logic [15:0] SR_ERR = 16'h00B0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_wbytes = 3'd2;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          tbl_rd;
  logic [NW-1:0] tbl_addr;
  logic [7:0]    tbl_data;
  logic          cmd_unknown;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic last_unk;
  logic [DW-1:0] v;
  logic [DW-1:0] ref_mem [64];

  always #5 clk = ~clk;

  assign tbl_data = tbl_addr[7:0] ^ 8'h3C;

  nfc_flash_cmd #(.BUS_BYTES(2), .ADDR_W(AW), .ARR_WORDS(64), .BLK_WORDS(16),
                  .MAKER_CODE(MAKER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_wbytes(bus_wbytes), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .tbl_rd(tbl_rd), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .cmd_unknown(cmd_unknown)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [2:0] nb);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wbytes = nb; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    last_unk = cmd_unknown;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] val);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    val = bus_rdata;
  endtask

  function automatic logic [AW-1:0] wa(input int i);
    return AW'(i * 2);
  endfunction

  function automatic logic [15:0] pat1(input int i);
    return 16'(i * 16'h1357) ^ 16'hC3A5;
  endfunction

  function automatic logic [15:0] pat2(input int i);
    return ~16'(i * 16'h0421) ^ 16'h0F0F;
  endfunction

  task automatic check_array(input string tag);
    for (int i = 0; i < 64; i++) begin
      rd(wa(i), v);
      chk(tag, v, ref_mem[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: blank array, ready status after reset
    check_array("R1 blank array");
    wr(0, 16'h0020, 3'd2);
    rd(0, v); chk("R1/R10 reset status in erase setup", v, SR_OK);
    wr(0, 16'h00FF, 3'd2);   // R2: leave erase setup
    rd(wa(3), v); chk("R2 back to array from erase setup", v, 16'hFFFF);

    // R6: program sweep, then AND merge sweep
    for (int i = 0; i < 64; i++) begin
      wr(wa(i), (i % 2) ? 16'h0040 : 16'h0010, 3'd2);
      wr(wa(i), pat1(i), 3'd2);
      ref_mem[i] = ref_mem[i] & pat1(i);
      if (i % 16 == 0) begin
        rd(wa(i), v); chk("R6 status after program", v, SR_OK);
      end
      wr(0, 16'h00F0, 3'd2);
    end
    check_array("R6 first program");
    for (int i = 0; i < 64; i++) begin
      wr(wa(i), 16'h0040, 3'd2);
      wr(wa(i), pat2(i), 3'd2);
      ref_mem[i] = ref_mem[i] & pat2(i);
      wr(0, 16'h00FF, 3'd2);
    end
    check_array("R6 AND merge");

    // R6: 0xFF in program setup is data
    wr(wa(5), 16'h0040, 3'd2);
    rd(wa(5), v); chk("R13 read in program setup", v, 16'h0000);
    wr(wa(5), 16'h00FF, 3'd2);
    rd(wa(5), v); chk("R6 FF taken as data, status mode", v, SR_OK);
    ref_mem[5] = ref_mem[5] & 16'h00FF;
    wr(0, 16'h00FF, 3'd2);
    rd(wa(5), v); chk("R6 FF data merged", v, ref_mem[5]);

    // R5: wrong width ignored in program setup and in array mode
    wr(wa(9), 16'h0010, 3'd2);
    wr(wa(9), 16'h0000, 3'd4);
    wr(wa(9), 16'hFF0F, 3'd1);
    wr(wa(9), 16'hF0FF, 3'd2);
    ref_mem[9] = ref_mem[9] & 16'hF0FF;
    wr(0, 16'h00FF, 3'd2);
    rd(wa(9), v); chk("R5 mismatched data writes ignored", v, ref_mem[9]);
    wr(0, 16'h0090, 3'd1);
    rd(wa(2), v); chk("R5 mismatched command ignored", v, ref_mem[2]);

    // R7: erase block 2 by an unaligned word address (word 37)
    wr(wa(37), 16'h0020, 3'd2);
    wr(wa(37), 16'h00D0, 3'd2);
    rd(wa(37), v); chk("R7 status after erase", v, SR_OK);
    for (int i = 32; i < 48; i++) ref_mem[i] = 16'hFFFF;
    wr(0, 16'h00FF, 3'd2);
    check_array("R7 block erased");

    // R7: bad confirm value
    wr(wa(20), 16'h0020, 3'd2);
    wr(wa(20), 16'h0033, 3'd2);
    rd(wa(20), v); chk("R7 erase error status", v, SR_ERR);
    wr(0, 16'h00FF, 3'd2);
    rd(wa(20), v); chk("R7 no erase on bad value", v, ref_mem[20]);

    // R12: unknown command keeps mode and status
    wr(0, 16'h0077, 3'd2);
    chk("R12 unknown flag raised", last_unk, 1);
    @(negedge clk); chk("R12 unknown flag one cycle", cmd_unknown, 0);
    rd(wa(20), v); chk("R12 mode unchanged", v, ref_mem[20]);
    wr(0, 16'h0020, 3'd2);
    rd(0, v); chk("R12 errors kept after unknown", v, SR_ERR);
    wr(0, 16'h00FF, 3'd2);
    chk("R2 no flag for reset", last_unk, 0);

    // R9: clear status from array mode
    wr(0, 16'h0050, 3'd2);
    chk("R9 clear status not unknown", last_unk, 0);
    rd(wa(4), v); chk("R9 still array mode", v, ref_mem[4]);
    wr(0, 16'h0020, 3'd2);
    rd(0, v); chk("R9 status cleared", v, SR_OK);
    wr(0, 16'h00FF, 3'd2);

    // R8: protection setup
    wr(0, 16'h0060, 3'd2);
    rd(0, v); chk("R13 read in protect setup", v, 16'h0000);
    wr(wa(1), 16'h002F, 3'd2);
    rd(0, v); chk("R8 lock-down accepted", v, SR_OK);
    wr(0, 16'h00FF, 3'd2);
    wr(0, 16'h0060, 3'd2);
    wr(0, 16'h0001, 3'd2);
    rd(0, v); chk("R8 lock accepted", v, SR_OK);
    wr(0, 16'h00F0, 3'd2);
    rd(wa(1), v); chk("R8 array untouched", v, ref_mem[1]);
    wr(0, 16'h0060, 3'd2);
    wr(0, 16'h0077, 3'd2);
    rd(0, v); chk("R8 bad value error", v, SR_ERR);
    // R12: command in status mode is unknown
    wr(0, 16'h0020, 3'd2);
    chk("R12 unknown in status mode", last_unk, 1);
    rd(0, v); chk("R12 status mode kept", v, SR_ERR);
    wr(0, 16'h00FF, 3'd2);

    // R11: identifier reads, R9 from identifier mode
    wr(0, 16'h0090, 3'd2);
    rd(AW'(0 << 1), v); chk("R11 maker code", v, MAKER);
    rd(AW'(1 << 1), v); chk("R11 device code", v, 16'h00AD);
    rd(AW'(2 << 1), v); chk("R11 lock state", v, 16'h0000);
    rd(AW'(5 << 1), v); chk("R11 config word", v, 16'h8000);
    rd(AW'(3 << 1), v); chk("R11 unmapped offset", v, 16'h0000);
    rd(AW'(9'h101 << 1), v); chk("R11 bit 8 decoded", v, 16'h0000);
    wr(0, 16'h0050, 3'd2);
    rd(AW'(1 << 1), v); chk("R9 ident mode kept", v, 16'h00AD);
    wr(0, 16'h0020, 3'd2);
    rd(0, v); chk("R9 clear from ident", v, SR_OK);
    wr(0, 16'h00FF, 3'd2);

    // R3/R4: query entry only at normalised 0x55 (byte 0xAA)
    wr(AW'(10'h055), 16'h0098, 3'd2);
    chk("R3 wrong address no flag", last_unk, 0);
    rd(AW'(10'h055), v); chk("R4 byte 0x55 is word 0x2A", v, ref_mem[6'h2A]);
    wr(AW'(10'h0AA), 16'h0098, 3'd2);
    for (int k = 0; k < 8; k++) begin
      rd(AW'((k * 37) << 1), v);
      chk("R3/R4 query table read", v, 16'(8'((k * 37) & 8'hFF) ^ 8'h3C));
    end
    wr(0, 16'h0090, 3'd2);
    chk("R12 ident in query mode unknown", last_unk, 1);
    rd(AW'(16 << 1), v); chk("R3 still query", v, 16'h002C);
    wr(0, 16'h00FF, 3'd2);
    rd(wa(16), v); chk("R2 back from query", v, ref_mem[16]);

    // R3: query from identifier mode
    wr(0, 16'h0090, 3'd2);
    wr(AW'(10'h0AA), 16'h0098, 3'd2);
    rd(AW'(3 << 1), v); chk("R3 query from ident", v, 16'h003F);
    wr(0, 16'h00F0, 3'd2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule